// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible face of a simple serial port. A 32-bit bus master reads and writes a set of 16-bit registers through byte addresses. The register is picked by the word index, which is the address with its two low bits dropped. Transmit bytes that software writes go out on a valid/ready byte stream. Received bytes, and break events, come in on a byte stream and land in a single holding register. Software empties that register by reading it.

Two status words and a test word report the receive and transmit state. A number of control, baud, FIFO-control and millisecond registers only keep what software writes so that it can read it back. A write to the second control word with its reset bit at zero triggers a soft reset. One level interrupt combines receive-ready with a transmit-ready term, and that term needs two enables.

A synchronous power-on reset loads the soft-reset values. On top of those it turns on the port enable and the transmit enable, so output works without any setup by software.

Top module: `serial_csr`

## Requirements
- R1: After power-on reset, reads return these values. Word index 0x20 (first control) = 0x0001. 0x21 (second control) = 0x0005. 0x22 (third control) = 0x0700. 0x25 (first status) = 0x6040. 0x26 (second status) = 0x4028. 0x2D (test) = 0x0060. 0x2B (baud count) = 0x0004. 0x2A (modulator), 0x24 (FIFO control) and 0x2C (millisecond) = 0. 0x00 (receive data) = 0x4000. In the same state irq and tx_valid are low and rx_ready is high.
- R2: Read data appears on rdata one cycle after rd_en. The register at word index 0x23, index 0x29 and every unmapped index read as zero. A cycle with both wr_en and rd_en acts as a write only.
- R3: While rx_ready is high, an rx_valid byte is stored in the holding register. Storing it sets first-status bit 9 and second-status bit 0, clears test bit 5, and drops rx_ready.
- R4: An rx_valid cycle with rx_break high stores the value 0x0800 in place of rx_data.
- R5: A read of index 0x00 while a character is held returns the held value with bit 15 set. The same read clears first-status bit 9 and second-status bit 0, sets test bit 5, and raises rx_ready. A read while nothing is held returns the stored value with bit 15 clear and changes nothing.
- R6: A write to index 0x10 while second-control bit 2 is set presents the low byte of wdata on tx_data, with tx_valid high, one cycle later. The byte is held until tx_ready. A further write while the byte is still undelivered is dropped.
- R7: A write to index 0x10 while second-control bit 2 is clear has no effect on the transmit stream.
- R8: Writing a 1 clears a status bit only for first-status bits 15, 12, 11, 10, 8, 7, 5, 4 and second-status bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2, 1. Every other written bit is ignored, so writing 0xFFFF leaves 0x6040 and 0x4028 in place.
- R9: irq is high when first-status bit 9 and first-control bit 9 are both set. It is also high when first-status bit 13, first-control bit 13 and first-control bit 6 are all set.
- R10: Writing index 0x21 with bit 0 zero performs a soft reset. The soft reset restores the R1 values of the first control word (to 0), both status words, the test word, the third control word, the modulator, the baud count and the holding register (0x4000, empty). The FIFO-control and millisecond registers keep their values. The second control word stores the written value with bit 0 forced to 1.
- R11: Writes to indices 0x20, 0x21, 0x22, 0x24, 0x2A and 0x2C keep the low 16 bits. A write to index 0x29 loads the baud count that reads back at 0x2B. Writes to 0x2B, 0x2D, 0x23 and unmapped indices are ignored.
- R12: While a character is held, rx_ready stays low. A second byte offered then is not taken, and the held byte is not overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; word index is addr[ADDR_W-1:2] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink accepts the byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_break | input | 1 | Offered item is a break event |
| rx_ready | output | 1 | Holding register is empty and will take a byte |

## Verification
Every result is due exactly one clock edge after its stimulus. That covers a read's rdata, a write's effect on any register or on tx_valid/tx_data, an accepted receive byte's effect on rx_ready and the status words, and the interrupt level, which follows the registers at once. The bench drives each stimulus on a falling edge and samples on the next falling edge, with a single rising edge in between. Sweeps run over all 256 receive bytes, a range of transmit bytes and every combination of the three interrupt-relevant control bits with the receiver both full and empty. The expected words are computed from the bit positions given in the requirements.

// File: rtl/scsr_pkg.sv
package scsr_pkg;
  // word indices (address >> 2)
  localparam int IX_RXD   = 'h00;
  localparam int IX_TXD   = 'h10;
  localparam int IX_CTRL1 = 'h20;
  localparam int IX_CTRL2 = 'h21;
  localparam int IX_CTRL3 = 'h22;
  localparam int IX_CTRL4 = 'h23;
  localparam int IX_FIFO  = 'h24;
  localparam int IX_STAT1 = 'h25;
  localparam int IX_STAT2 = 'h26;
  localparam int IX_BINC  = 'h29;
  localparam int IX_BMOD  = 'h2A;
  localparam int IX_BCNT  = 'h2B;
  localparam int IX_MSEC  = 'h2C;
  localparam int IX_TEST  = 'h2D;

  // bit positions
  localparam int B_TRDY    = 13;
  localparam int B_RRDY    = 9;
  localparam int B_TXIEN   = 6;
  localparam int B_PORTEN  = 0;
  localparam int B_TXEN    = 2;
  localparam int B_NSRST   = 0;
  localparam int B_DRDY    = 0;
  localparam int B_CHARRDY = 15;
  localparam int B_TXEMPTY = 6;
  localparam int B_RXEMPTY = 5;

  // masks and reset values
  localparam logic [15:0] ST1_CLRMASK = 16'h9DB0;
  localparam logic [15:0] ST2_CLRMASK = 16'hBDD6;
  localparam logic [15:0] ST1_INIT    = 16'h6040;
  localparam logic [15:0] ST2_INIT    = 16'h4028;
  localparam logic [15:0] BCNT_INIT   = 16'h0004;
  localparam logic [15:0] HOLD_INIT   = 16'h4000;
  localparam logic [15:0] BREAK_CODE  = 16'h0800;

  // plain read/write registers
  localparam int NUM_PLAIN = 4;

  function automatic int plain_index(input int i);
    case (i)
      0:       return IX_CTRL3;
      1:       return IX_FIFO;
      2:       return IX_BMOD;
      default: return IX_MSEC;
    endcase
  endfunction

  function automatic logic [15:0] plain_init(input int i);
    return (i == 0) ? 16'h0700 : 16'h0000;
  endfunction

  function automatic bit plain_soft(input int i);
    return (i == 0) || (i == 2);
  endfunction
endpackage

// File: rtl/scsr_rx_hold.sv
module scsr_rx_hold
  import scsr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              consume,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              full,
  output logic [REG_W-1:0]  hold,
  output logic              rx_ready
);
  logic take;
  assign rx_ready = ~full;
  assign take     = rx_valid & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      hold <= REG_W'(HOLD_INIT);
    end else begin
      if (soft_rst) begin
        full <= 1'b0;
        hold <= REG_W'(HOLD_INIT);
      end
      if (consume) begin
        full <= 1'b0;
      end
      if (take) begin
        full <= 1'b1;
        hold <= rx_break ? REG_W'(BREAK_CODE) : REG_W'(rx_data);
      end
    end
  end
endmodule

// File: rtl/scsr_tx_slot.sv
module scsr_tx_slot #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  logic room;
  assign room = ~tx_valid | tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (push && room) begin
      tx_valid <= 1'b1;
      tx_data  <= push_data;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/scsr_ctrl_bank.sv
module scsr_ctrl_bank
  import scsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_full,
  input  logic [REG_W-1:0]  rx_hold,
  output logic              soft_rst,
  output logic              consume,
  output logic              tx_push,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [REG_W-1:0]  ctrl1_o,
  output logic [REG_W-1:0]  ctrl2_o,
  output logic [REG_W-1:0]  stat1_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] wval;
  logic             rd_act;
  logic [REG_W-1:0] ctrl1_q, ctrl2_q, stat1_q, stat2_q, bcnt_q;
  logic [REG_W-1:0] stat1_v, stat2_v, test_v, rxd_v;
  logic [REG_W-1:0] plain_q [NUM_PLAIN];
  logic [DATA_W-1:0] rd_val;

  assign idx    = addr[ADDR_W-1:2];
  assign wval   = wdata[REG_W-1:0];
  assign rd_act = rd_en & ~wr_en;

  function automatic logic hit(input logic [IDX_W-1:0] a, input int ix);
    return a == IDX_W'(ix);
  endfunction

  assign soft_rst = wr_en & hit(idx, IX_CTRL2) & ~wdata[B_NSRST];
  assign consume  = rd_act & hit(idx, IX_RXD) & rx_full;
  assign tx_push  = wr_en & hit(idx, IX_TXD) & ctrl2_q[B_TXEN];

  // views with live receive flags
  always_comb begin
    stat1_v           = stat1_q;
    stat1_v[B_RRDY]   = rx_full;
    stat2_v           = stat2_q;
    stat2_v[B_DRDY]   = rx_full;
    test_v            = '0;
    test_v[B_TXEMPTY] = 1'b1;
    test_v[B_RXEMPTY] = ~rx_full;
    rxd_v             = rx_hold;
    rxd_v[B_CHARRDY]  = rx_hold[B_CHARRDY] | rx_full;
  end

  // dedicated registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl1_q <= '0;
      ctrl1_q[B_PORTEN] <= 1'b1;
      ctrl2_q <= '0;
      ctrl2_q[B_NSRST] <= 1'b1;
      ctrl2_q[B_TXEN]  <= 1'b1;
      stat1_q <= REG_W'(ST1_INIT);
      stat2_q <= REG_W'(ST2_INIT);
      bcnt_q  <= REG_W'(BCNT_INIT);
    end else if (wr_en) begin
      if (soft_rst) begin
        ctrl1_q <= '0;
        stat1_q <= REG_W'(ST1_INIT);
        stat2_q <= REG_W'(ST2_INIT);
        bcnt_q  <= REG_W'(BCNT_INIT);
      end
      if (hit(idx, IX_CTRL1)) ctrl1_q <= wval;
      if (hit(idx, IX_CTRL2)) ctrl2_q <= wval | REG_W'(1 << B_NSRST);
      if (hit(idx, IX_STAT1)) stat1_q <= stat1_q & ~(wval & REG_W'(ST1_CLRMASK));
      if (hit(idx, IX_STAT2)) stat2_q <= stat2_q & ~(wval & REG_W'(ST2_CLRMASK));
      if (hit(idx, IX_BINC))  bcnt_q  <= wval;
    end
  end

  // store-and-return registers
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst) begin
        plain_q[g] <= REG_W'(plain_init(g));
      end else if (wr_en && hit(idx, plain_index(g))) begin
        plain_q[g] <= wval;
      end else if (soft_rst && plain_soft(g)) begin
        plain_q[g] <= REG_W'(plain_init(g));
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit(idx, IX_RXD))   rd_val = DATA_W'(rxd_v);
    if (hit(idx, IX_CTRL1)) rd_val = DATA_W'(ctrl1_q);
    if (hit(idx, IX_CTRL2)) rd_val = DATA_W'(ctrl2_q);
    if (hit(idx, IX_STAT1)) rd_val = DATA_W'(stat1_v);
    if (hit(idx, IX_STAT2)) rd_val = DATA_W'(stat2_v);
    if (hit(idx, IX_BCNT))  rd_val = DATA_W'(bcnt_q);
    if (hit(idx, IX_TEST))  rd_val = DATA_W'(test_v);
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (hit(idx, plain_index(i))) rd_val = DATA_W'(plain_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_act) begin
      rdata <= rd_val;
    end
  end

  assign irq = (stat1_v[B_RRDY] & ctrl1_q[B_RRDY])
             | (stat1_v[B_TRDY] & ctrl1_q[B_TRDY] & ctrl1_q[B_TXIEN]);

  assign ctrl1_o = ctrl1_q;
  assign ctrl2_o = ctrl2_q;
  assign stat1_o = stat1_v;
endmodule

// File: rtl/serial_csr.sv
module serial_csr
  import scsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_ready
);
  logic             soft_rst, consume, tx_push, rx_full;
  logic [REG_W-1:0] rx_hold, ctrl1_w, ctrl2_w, stat1_w;

  scsr_ctrl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rx_full(rx_full), .rx_hold(rx_hold),
    .soft_rst(soft_rst), .consume(consume), .tx_push(tx_push),
    .rdata(rdata), .irq(irq), .ctrl1_o(ctrl1_w), .ctrl2_o(ctrl2_w),
    .stat1_o(stat1_w)
  );

  scsr_rx_hold #(.BYTE_W(BYTE_W), .REG_W(REG_W)) u_rx (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .consume(consume),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .full(rx_full), .hold(rx_hold), .rx_ready(rx_ready)
  );

  scsr_tx_slot #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .push(tx_push), .push_data(wdata[BYTE_W-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );
endmodule

// File: rtl/scsr_checker.sv
module scsr_checker
  import scsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int REG_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [REG_W-1:0]  ctrl1,
  input logic [REG_W-1:0]  ctrl2,
  input logic [REG_W-1:0]  stat1
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));  // R6

  AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
    wr_en && idx == IDX_W'(IX_TXD) && !ctrl2[B_TXEN] && !tx_valid |=> !tx_valid);  // R7

  AST_RX_TAKEN: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready |=> !rx_ready);  // R3

  AST_RX_DRAINED: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && idx == IDX_W'(IX_RXD) && !rx_ready |=> rx_ready);  // R5

  AST_STAT_KEPT: assert property (@(posedge clk) disable iff (rst)
    wr_en && idx == IDX_W'(IX_STAT1)
    |=> $stable(stat1[14]) && $stable(stat1[B_TRDY]) && $stable(stat1[6]));  // R8

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl1[B_RRDY] || ctrl1[B_TXIEN]);  // R9
endmodule

bind serial_csr scsr_checker #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
  .ctrl1(ctrl1_w), .ctrl2(ctrl2_w), .stat1(stat1_w)
);

// File: tb/test_serial_csr.sv
module test_serial_csr;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, tx_valid, rx_ready;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  serial_csr #(.ADDR_W(ADDR_W)) i_serial_csr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_break(rx_break), .rx_ready(rx_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int ix, input logic [31:0] d);
    addr = ADDR_W'(ix << 2); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ix, output logic [31:0] v);
    addr = ADDR_W'(ix << 2); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rx_push(input logic [7:0] b, input logic brk);
    rx_data = b; rx_break = brk; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic expect_reg(input string req, input int ix, input logic [31:0] exp);
    logic [31:0] v;
    rd(ix, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 tx_valid", {31'b0, tx_valid}, 0);
    check("R1 rx_ready", {31'b0, rx_ready}, 1);
    expect_reg("R1 ctrl1", 'h20, 32'h0001);
    expect_reg("R1 ctrl2", 'h21, 32'h0005);
    expect_reg("R1 ctrl3", 'h22, 32'h0700);
    expect_reg("R1 stat1", 'h25, 32'h6040);
    expect_reg("R1 stat2", 'h26, 32'h4028);
    expect_reg("R1 test", 'h2D, 32'h0060);
    expect_reg("R1 bcnt", 'h2B, 32'h0004);
    expect_reg("R1 bmod", 'h2A, 32'h0);
    expect_reg("R1 fifo", 'h24, 32'h0);
    expect_reg("R1 msec", 'h2C, 32'h0);
    expect_reg("R1 rxd", 'h00, 32'h4000);

    // R2 zero-reading indices
    expect_reg("R2 ctrl4", 'h23, 0);
    expect_reg("R2 binc", 'h29, 0);
    expect_reg("R2 unmapped 0x01", 'h01, 0);
    expect_reg("R2 unmapped 0x3F", 'h3F, 0);

    // R3 / R5 sweep over every receive byte
    for (int b = 0; b < 256; b++) begin
      rx_push(8'(b), 1'b0);
      check("R3 rx_ready low", {31'b0, rx_ready}, 0);
      if (b % 64 == 0) begin
        expect_reg("R3 stat1", 'h25, 32'h6240);
        expect_reg("R3 stat2", 'h26, 32'h4029);
        expect_reg("R3 test", 'h2D, 32'h0040);
      end
      expect_reg("R5 rxd full", 'h00, 32'h8000 | b);
      check("R5 rx_ready high", {31'b0, rx_ready}, 1);
      expect_reg("R5 rxd empty", 'h00, 32'(b));
    end
    expect_reg("R5 stat1 cleared", 'h25, 32'h6040);
    expect_reg("R5 test set", 'h2D, 32'h0060);

    // R4 break
    rx_push(8'h5A, 1'b1);
    expect_reg("R4 break", 'h00, 32'h8800);

    // R12 no overwrite while full
    rx_push(8'h11, 1'b0);
    rx_push(8'h22, 1'b0);
    check("R12 rx_ready low", {31'b0, rx_ready}, 0);
    expect_reg("R12 held byte", 'h00, 32'h8011);

    // R6 transmit sweep with sink ready
    tx_ready = 1'b1;
    for (int b = 0; b < 256; b += 5) begin
      wr('h10, {24'hA5C3E1, 8'(b)});
      check("R6 tx_valid", {31'b0, tx_valid}, 1);
      check("R6 tx_data", {24'b0, tx_data}, 32'(b));
      @(negedge clk);
      check("R6 drained", {31'b0, tx_valid}, 0);
    end
    // R6 write while undelivered is dropped
    tx_ready = 1'b0;
    wr('h10, 32'h41);
    wr('h10, 32'h42);
    check("R6 held first", {24'b0, tx_data}, 32'h41);
    check("R6 still valid", {31'b0, tx_valid}, 1);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R6 nothing queued", {31'b0, tx_valid}, 0);

    // R7 transmit disabled
    wr('h21, 32'h0001);
    wr('h10, 32'h77);
    check("R7 tx ignored", {31'b0, tx_valid}, 0);
    wr('h21, 32'h0005);

    // R8 protected status bits
    wr('h25, 32'hFFFF_FFFF);
    wr('h26, 32'hFFFF_FFFF);
    expect_reg("R8 stat1", 'h25, 32'h6040);
    expect_reg("R8 stat2", 'h26, 32'h4028);

    // R9 interrupt sweep, receiver empty then full
    for (int full = 0; full < 2; full++) begin
      if (full == 1) rx_push(8'h33, 1'b0);
      for (int m = 0; m < 8; m++) begin
        logic [31:0] c1;
        logic exp_irq;
        c1 = 0;
        c1[13] = m[2]; c1[9] = m[1]; c1[6] = m[0];
        wr('h20, c1);
        exp_irq = (m[1] && full == 1) || (m[2] && m[0]);
        check("R9 irq", {31'b0, irq}, {31'b0, exp_irq});
      end
    end
    rd('h00, v);
    check("R9 irq after drain", {31'b0, irq}, 32'(1));  // ctrl1 = bits 13|9|6
    wr('h20, 32'h0001);

    // R11 width and odd indices
    wr('h22, 32'h1234_5678);
    expect_reg("R11 ctrl3", 'h22, 32'h5678);
    wr('h20, 32'hDEAD_BEE1);
    expect_reg("R11 ctrl1", 'h20, 32'hBEE1);
    wr('h20, 32'h0001);
    wr('h29, 32'hFFFF_1111);
    expect_reg("R11 bcnt via binc", 'h2B, 32'h1111);
    expect_reg("R11 binc reads 0", 'h29, 0);
    wr('h2B, 32'h2222);
    expect_reg("R11 bcnt write ignored", 'h2B, 32'h1111);
    wr('h2D, 32'hFFFF);
    expect_reg("R11 test write ignored", 'h2D, 32'h0060);
    wr('h23, 32'h55);
    expect_reg("R11 ctrl4", 'h23, 0);
    wr('h24, 32'hABCD_1234);
    wr('h2C, 32'h0000_ABCD);
    wr('h2A, 32'h0000_0099);

    // R2 write wins over read in the same cycle
    rd('h24, v);
    addr = ADDR_W'('h22 << 2); wdata = 32'h0BAD; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R2 rdata unchanged", rdata, 32'h1234);
    expect_reg("R2 write taken", 'h22, 32'h0BAD);

    // R10 soft reset
    rx_push(8'h66, 1'b0);
    wr('h20, 32'h0241);
    wr('h21, 32'h0006);
    expect_reg("R10 ctrl2", 'h21, 32'h0007);
    expect_reg("R10 ctrl1", 'h20, 32'h0);
    expect_reg("R10 ctrl3", 'h22, 32'h0700);
    expect_reg("R10 stat1", 'h25, 32'h6040);
    expect_reg("R10 stat2", 'h26, 32'h4028);
    expect_reg("R10 test", 'h2D, 32'h0060);
    expect_reg("R10 bcnt", 'h2B, 32'h0004);
    expect_reg("R10 bmod", 'h2A, 32'h0);
    expect_reg("R10 fifo kept", 'h24, 32'h1234);
    expect_reg("R10 msec kept", 'h2C, 32'hABCD);
    expect_reg("R10 rxd", 'h00, 32'h4000);
    check("R10 rx_ready", {31'b0, rx_ready}, 1);
    check("R10 irq", {31'b0, irq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule